// File: doc/BRIEF.md
# Paravirtual Device Common Configuration Register Block

This block holds the common configuration registers of a paravirtual device that a host processor reaches over a small memory-mapped request/response port. Each request carries a byte offset, a size code giving the byte count (1, 2, 4 or 8) and little-endian write data. The block keeps the device-wide registers: the two 32-bit feature-page selects, a configuration interrupt vector, the device status byte and a read-only generation byte. It also keeps one set of per-queue registers for each of `NUM_QUEUES` queues: size, interrupt vector, enable, and three 64-bit ring base addresses. A queue-select register picks which set the per-queue offsets reach.

The 64-bit feature word the device offers comes in on a port and is read through a 32-bit window that the device feature select positions. A write to the driver feature register produces a one-cycle acknowledge pulse. The pulse carries the written 32 bits shifted to the page chosen by the driver feature select. The queue configuration (size, enable and ring addresses) is driven out to the queue engines on plain output pins. Ring addresses are write-only on the register port.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on `rsp_valid`/`rsp_rdata` one cycle later and is held until `rsp_ready` is high. `req_ready` is low while a response is pending and `rsp_ready` is low, so a stalled consumer back-pressures the requester with at most one response in flight.

Top module: `pvdev_cfg_regs`

## Requirements
- R1: A request is accepted on an edge with req_valid and req_ready high. Its response is valid from the next cycle. req_ready equals (not rsp_valid) or rsp_ready, and a response that is not taken keeps rsp_rdata unchanged.
- R2: After reset every register is zero except the generation byte, which equals GEN_INIT. A 2-byte read at 0x12 returns NUM_QUEUES.
- R3: Decode depends on size. 1-byte accesses hit only 0x14 (status) and 0x15 (generation). 2-byte accesses hit only 0x10, 0x12, 0x16, 0x18, 0x1A, 0x1C and 0x1E. 4-byte reads hit only 0x00, 0x04 and 0x08. 8-byte reads return zero, and a read of any other offset/size pair returns zero.
- R4: A 4-byte read at 0x04 returns feature bits [32*s+31:32*s] for a device feature select s of 0 or 1, and zero for any larger s.
- R5: A 4-byte write at 0x0C with driver feature select s below 2 raises feat_ack_valid for exactly one cycle, with feat_ack_bits = data << (32*s). With a larger s, no pulse occurs.
- R6: Write data sits in req_wdata[8*size-1:0], with the byte at the lowest offset in bits [7:0]. Read data is returned zero-extended in the same lanes. Both feature selects (0x00, 0x08) read back what was written.
- R7: The status byte at 0x14 is fully writable. A write to the generation byte at 0x15 is ignored.
- R8: A 2-byte read at 0x1E (notify offset) returns the current queue select (0x16).
- R9: Queue size (0x18) and queue vector (0x1A) are held per queue and read back for the selected queue. The selected queue's size also appears on q_size_o, in lane 16*q.
- R10: A 2-byte write at 0x1C sets the selected queue's enable only when the value is exactly 1, and clears it for any other value. A read returns 1 or 0.
- R11: 4-byte writes at 0x20/0x24, 0x28/0x2C and 0x30/0x34 load the low and high halves of the descriptor, available and used ring addresses. An 8-byte write at 0x20, 0x28 or 0x30 loads both halves. The addresses appear on q_desc_o, q_avail_o and q_used_o (lane 64*q) and read as zero on the port.
- R12: With queue select at or above NUM_QUEUES, per-queue reads return zero and per-queue writes change nothing.
- R13: A size code outside {1,2,4,8} gives a zero response and changes no state. Writes to read-only or unknown offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the access |
| req_size | input | 4 | Byte count: 1, 2, 4 or 8 |
| req_wdata | input | 64 | Little-endian write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Read data, zero-extended |
| dev_features | input | 64 | Feature bits offered by the device |
| feat_ack_valid | output | 1 | One-cycle driver-feature acknowledge |
| feat_ack_bits | output | 64 | Acknowledged bits placed at the selected page |
| q_size_o | output | 16*NUM_QUEUES | Per-queue size |
| q_enable_o | output | NUM_QUEUES | Per-queue enable |
| q_desc_o | output | 64*NUM_QUEUES | Per-queue descriptor ring address |
| q_avail_o | output | 64*NUM_QUEUES | Per-queue available ring address |
| q_used_o | output | 64*NUM_QUEUES | Per-queue used ring address |

## Verification
A wrong queue select or a bad per-queue decode moves data into the wrong lane of the queue outputs on the edge after the write. It also shows in the next read response, one cycle after that read is accepted. A mis-set feature page shows in the very next read of 0x04, or as an acknowledge pulse in the wrong half of feat_ack_bits on the cycle after the 0x0C write. A size-decode fault shows as a non-zero response to an access that should miss, or as a later read-back that has changed. Handshake state errors show at once: req_ready stays low, or a held response changes while rsp_ready is low.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;
  localparam int OFS_W = 6;

  localparam logic [3:0] SZ_B = 4'd1;
  localparam logic [3:0] SZ_H = 4'd2;
  localparam logic [3:0] SZ_W = 4'd4;
  localparam logic [3:0] SZ_D = 4'd8;

  localparam logic [OFS_W-1:0] OFS_DFSEL  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_DFEAT  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_DRFSEL = 6'h08;
  localparam logic [OFS_W-1:0] OFS_DRFEAT = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_CFGVEC = 6'h10;
  localparam logic [OFS_W-1:0] OFS_NQ     = 6'h12;
  localparam logic [OFS_W-1:0] OFS_STAT   = 6'h14;
  localparam logic [OFS_W-1:0] OFS_GEN    = 6'h15;
  localparam logic [OFS_W-1:0] OFS_QSEL   = 6'h16;
  localparam logic [OFS_W-1:0] OFS_QSIZE  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_QVEC   = 6'h1A;
  localparam logic [OFS_W-1:0] OFS_QEN    = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_NOTIFY = 6'h1E;

  localparam int NRINGS = 3;
  localparam logic [OFS_W-1:0] RING_BASE [NRINGS] = '{6'h20, 6'h28, 6'h30};

  function automatic logic size_legal(input logic [3:0] s);
    return (s == SZ_B) || (s == SZ_H) || (s == SZ_W) || (s == SZ_D);
  endfunction
endpackage

// File: rtl/pvcfg_feat_window.sv
module pvcfg_feat_window #(
  parameter int FEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FEAT_W-1:0] dev_features,
  input  logic [31:0]       dev_sel,
  input  logic [31:0]       drv_sel,
  input  logic              ack_we,
  input  logic [31:0]       ack_wdata,
  output logic [31:0]       page_o,
  output logic              ack_valid_o,
  output logic [FEAT_W-1:0] ack_bits_o
);
  localparam int NPAGES = FEAT_W / 32;

  always_comb begin
    page_o = '0;
    for (int p = 0; p < NPAGES; p++) begin
      if (dev_sel == 32'(p)) page_o = dev_features[32*p +: 32];
    end
  end

  logic [FEAT_W-1:0] shifted;
  logic              drv_ok;
  always_comb begin
    shifted = '0;
    drv_ok  = 1'b0;
    for (int p = 0; p < NPAGES; p++) begin
      if (drv_sel == 32'(p)) begin
        shifted[32*p +: 32] = ack_wdata;
        drv_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_bits_o  <= '0;
    end else begin
      ack_valid_o <= ack_we && drv_ok;
      ack_bits_o  <= (ack_we && drv_ok) ? shifted : '0;
    end
  end

  assert_ack_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> ($past(ack_we) && ($past(drv_sel) < 32'(NPAGES))));
  assert_ack_one_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> ($countones(ack_bits_o) <= 32));
  assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid_o |-> (ack_bits_o == '0));
endmodule

// File: rtl/pvcfg_queue_bank.sv
module pvcfg_queue_bank #(
  parameter int NUM_QUEUES = 4,
  parameter int SEL_W      = 16,
  parameter int RING_AW    = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              sel,
  input  logic                          wr_size,
  input  logic                          wr_vec,
  input  logic                          wr_enable,
  input  logic [15:0]                   wdata16,
  input  logic [2:0]                    ring_lo_we,
  input  logic [2:0]                    ring_hi_we,
  input  logic [RING_AW/2-1:0]          ring_lo_data,
  input  logic [RING_AW/2-1:0]          ring_hi_data,
  output logic [15:0]                   rd_size,
  output logic [15:0]                   rd_vec,
  output logic                          rd_enable,
  output logic [NUM_QUEUES*16-1:0]      q_size_o,
  output logic [NUM_QUEUES-1:0]         q_enable_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_desc_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_avail_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_used_o
);
  localparam int HALF = RING_AW / 2;
  localparam logic [SEL_W-1:0] NQ_L = SEL_W'(NUM_QUEUES);

  logic [15:0]        size_q [NUM_QUEUES];
  logic [15:0]        vec_q  [NUM_QUEUES];
  logic               en_q   [NUM_QUEUES];
  logic [RING_AW-1:0] ring_q [NUM_QUEUES][3];

  logic sel_ok;
  assign sel_ok = sel < NQ_L;

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_q
    logic hit;
    assign hit = (sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        size_q[g] <= '0;
        vec_q[g]  <= '0;
        en_q[g]   <= 1'b0;
      end else if (hit) begin
        if (wr_size)   size_q[g] <= wdata16;
        if (wr_vec)    vec_q[g]  <= wdata16;
        if (wr_enable) en_q[g]   <= (wdata16 == 16'd1);
      end
    end

    for (genvar r = 0; r < 3; r++) begin : g_ring
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ring_q[g][r] <= '0;
        end else if (hit) begin
          if (ring_lo_we[r]) ring_q[g][r][HALF-1:0]       <= ring_lo_data;
          if (ring_hi_we[r]) ring_q[g][r][RING_AW-1:HALF] <= ring_hi_data;
        end
      end
    end

    assign q_size_o[16*g +: 16]          = size_q[g];
    assign q_enable_o[g]                 = en_q[g];
    assign q_desc_o[RING_AW*g +: RING_AW]  = ring_q[g][0];
    assign q_avail_o[RING_AW*g +: RING_AW] = ring_q[g][1];
    assign q_used_o[RING_AW*g +: RING_AW]  = ring_q[g][2];
  end

  always_comb begin
    rd_size   = '0;
    rd_vec    = '0;
    rd_enable = 1'b0;
    for (int q = 0; q < NUM_QUEUES; q++) begin
      if (sel == SEL_W'(q)) begin
        rd_size   = size_q[q];
        rd_vec    = vec_q[q];
        rd_enable = en_q[q];
      end
    end
  end

  logic any_wr;
  assign any_wr = wr_size || wr_vec || wr_enable || (|ring_lo_we) || (|ring_hi_we);

  assert_oor_write_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !sel_ok) |=> ($stable(q_size_o) && $stable(q_enable_o) &&
                             $stable(q_desc_o) && $stable(q_avail_o) && $stable(q_used_o)));
  assert_oor_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (rd_size == '0 && rd_vec == '0 && !rd_enable));
  assert_enable_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && sel_ok) |=> (rd_enable == ($past(wdata16) == 16'd1)));
  assert_one_enable_per_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ($countones(q_enable_o ^ $past(q_enable_o)) <= 1));
endmodule

// File: rtl/pvdev_cfg_regs.sv
module pvdev_cfg_regs
  import pvcfg_pkg::*;
#(
  parameter int         NUM_QUEUES = 4,
  parameter logic [7:0] GEN_INIT   = 8'hA5,
  parameter int         FEAT_W     = 64,
  parameter int         RING_AW    = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [5:0]                    req_addr,
  input  logic [3:0]                    req_size,
  input  logic [63:0]                   req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [63:0]                   rsp_rdata,
  input  logic [FEAT_W-1:0]             dev_features,
  output logic                          feat_ack_valid,
  output logic [FEAT_W-1:0]             feat_ack_bits,
  output logic [NUM_QUEUES*16-1:0]      q_size_o,
  output logic [NUM_QUEUES-1:0]         q_enable_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_desc_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_avail_o,
  output logic [NUM_QUEUES*RING_AW-1:0] q_used_o
);
  localparam int SEL_W = 16;
  localparam int HALF  = RING_AW / 2;

  logic [31:0]      dfsel_q, drfsel_q;
  logic [15:0]      cfgvec_q;
  logic [7:0]       status_q, gen_q;
  logic [SEL_W-1:0] qsel_q;

  logic accept, size_ok, wr;
  logic wr8, wr16, wr32, wr64;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign size_ok   = size_legal(req_size);
  assign wr        = accept && req_write && size_ok;
  assign wr8  = wr && (req_size == SZ_B);
  assign wr16 = wr && (req_size == SZ_H);
  assign wr32 = wr && (req_size == SZ_W);
  assign wr64 = wr && (req_size == SZ_D);

  // Device-wide registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dfsel_q  <= '0;
      drfsel_q <= '0;
      cfgvec_q <= '0;
      status_q <= '0;
      gen_q    <= GEN_INIT;
      qsel_q   <= '0;
    end else begin
      if (wr8  && req_addr == OFS_STAT)   status_q <= req_wdata[7:0];
      if (wr16 && req_addr == OFS_CFGVEC) cfgvec_q <= req_wdata[15:0];
      if (wr16 && req_addr == OFS_QSEL)   qsel_q   <= req_wdata[SEL_W-1:0];
      if (wr32 && req_addr == OFS_DFSEL)  dfsel_q  <= req_wdata[31:0];
      if (wr32 && req_addr == OFS_DRFSEL) drfsel_q <= req_wdata[31:0];
    end
  end

  // Feature window and acknowledge
  logic [31:0] feat_page;
  pvcfg_feat_window #(.FEAT_W(FEAT_W)) u_feat (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_features (dev_features),
    .dev_sel      (dfsel_q),
    .drv_sel      (drfsel_q),
    .ack_we       (wr32 && req_addr == OFS_DRFEAT),
    .ack_wdata    (req_wdata[31:0]),
    .page_o       (feat_page),
    .ack_valid_o  (feat_ack_valid),
    .ack_bits_o   (feat_ack_bits)
  );

  // Per-queue strobes
  logic [2:0] ring_lo_we, ring_hi_we;
  for (genvar r = 0; r < NRINGS; r++) begin : g_rstb
    assign ring_lo_we[r] = (wr32 && req_addr == RING_BASE[r]) ||
                           (wr64 && req_addr == RING_BASE[r]);
    assign ring_hi_we[r] = (wr32 && req_addr == RING_BASE[r] + 6'd4) ||
                           (wr64 && req_addr == RING_BASE[r]);
  end

  logic [15:0] q_rd_size, q_rd_vec;
  logic        q_rd_en;
  pvcfg_queue_bank #(
    .NUM_QUEUES (NUM_QUEUES),
    .SEL_W      (SEL_W),
    .RING_AW    (RING_AW)
  ) u_qbank (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (qsel_q),
    .wr_size      (wr16 && req_addr == OFS_QSIZE),
    .wr_vec       (wr16 && req_addr == OFS_QVEC),
    .wr_enable    (wr16 && req_addr == OFS_QEN),
    .wdata16      (req_wdata[15:0]),
    .ring_lo_we   (ring_lo_we),
    .ring_hi_we   (ring_hi_we),
    .ring_lo_data (req_wdata[HALF-1:0]),
    .ring_hi_data (wr64 ? req_wdata[RING_AW-1:HALF] : req_wdata[HALF-1:0]),
    .rd_size      (q_rd_size),
    .rd_vec       (q_rd_vec),
    .rd_enable    (q_rd_en),
    .q_size_o     (q_size_o),
    .q_enable_o   (q_enable_o),
    .q_desc_o     (q_desc_o),
    .q_avail_o    (q_avail_o),
    .q_used_o     (q_used_o)
  );

  // Read decode, chosen by size
  logic [63:0] rd_value;
  always_comb begin
    rd_value = '0;
    if (!req_write) begin
      case (req_size)
        SZ_B: begin
          if (req_addr == OFS_STAT)     rd_value[7:0] = status_q;
          else if (req_addr == OFS_GEN) rd_value[7:0] = gen_q;
        end
        SZ_H: begin
          case (req_addr)
            OFS_CFGVEC: rd_value[15:0] = cfgvec_q;
            OFS_NQ:     rd_value[15:0] = 16'(NUM_QUEUES);
            OFS_QSEL:   rd_value[15:0] = qsel_q;
            OFS_QSIZE:  rd_value[15:0] = q_rd_size;
            OFS_QVEC:   rd_value[15:0] = q_rd_vec;
            OFS_QEN:    rd_value[15:0] = {15'd0, q_rd_en};
            OFS_NOTIFY: rd_value[15:0] = qsel_q;
            default:    rd_value = '0;
          endcase
        end
        SZ_W: begin
          case (req_addr)
            OFS_DFSEL:  rd_value[31:0] = dfsel_q;
            OFS_DFEAT:  rd_value[31:0] = feat_page;
            OFS_DRFSEL: rd_value[31:0] = drfsel_q;
            default:    rd_value = '0;
          endcase
        end
        default: rd_value = '0;
      endcase
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_rsp_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_wide_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_size == SZ_D) |=> (rsp_rdata == '0));
  assert_bad_size_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !size_ok) |=> (rsp_rdata == '0 && $stable(status_q) && $stable(qsel_q) &&
                              $stable(cfgvec_q) && $stable(dfsel_q) && $stable(drfsel_q) &&
                              !feat_ack_valid));
  assert_gen_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (gen_q == GEN_INIT));
endmodule

// File: tb/tb_pvdev_cfg_regs.sv
module tb_pvdev_cfg_regs;
  localparam int         NQ  = 4;
  localparam logic [7:0] GEN = 8'hA5;
  localparam logic [63:0] FEAT = 64'h1234_5678_9ABC_DEF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [5:0]  req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, feat_ack_valid;
  logic [63:0] rsp_rdata, feat_ack_bits;
  logic [NQ*16-1:0] q_size_o;
  logic [NQ-1:0]    q_enable_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;

  always #10 clk = ~clk;

  pvdev_cfg_regs #(.NUM_QUEUES(NQ), .GEN_INIT(GEN), .FEAT_W(64), .RING_AW(64)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dev_features(FEAT),
    .feat_ack_valid(feat_ack_valid), .feat_ack_bits(feat_ack_bits),
    .q_size_o(q_size_o), .q_enable_o(q_enable_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [63:0] last_rd;
  logic        last_ack_v;
  logic [63:0] last_ack_bits;

  task automatic xact(input logic w, input logic [5:0] a, input logic [3:0] s,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_rd       = rsp_rdata;
    last_ack_v    = feat_ack_valid;
    last_ack_bits = feat_ack_bits;
  endtask

  typedef struct packed {
    logic        wr;
    logic [5:0]  ofs;
    logic [3:0]  sz;
    logic [63:0] data;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h14, 4'd1, 64'h0, 64'h0, 8'd2},                    // R2 status reset
    '{1'b0, 6'h15, 4'd1, 64'h0, 64'hA5, 8'd2},                   // R2 generation reset
    '{1'b0, 6'h12, 4'd2, 64'h0, 64'h4, 8'd2},                    // R2 queue count
    '{1'b1, 6'h14, 4'd1, 64'hFFFF_FF55, 64'h0, 8'd7},            // R7 status write
    '{1'b0, 6'h14, 4'd1, 64'h0, 64'h55, 8'd7},                   // R7
    '{1'b1, 6'h15, 4'd1, 64'hAA, 64'h0, 8'd7},                   // R7 generation write ignored
    '{1'b0, 6'h15, 4'd1, 64'h0, 64'hA5, 8'd7},                   // R7
    '{1'b1, 6'h00, 4'd4, 64'h0403_0201, 64'h0, 8'd6},            // R6 little-endian select
    '{1'b0, 6'h00, 4'd4, 64'h0, 64'h0403_0201, 8'd6},            // R6
    '{1'b0, 6'h04, 4'd4, 64'h0, 64'h0, 8'd4},                    // R4 large select -> 0
    '{1'b1, 6'h00, 4'd4, 64'h1, 64'h0, 8'd4},                    // R4
    '{1'b0, 6'h04, 4'd4, 64'h0, 64'h1234_5678, 8'd4},            // R4 upper page
    '{1'b1, 6'h00, 4'd4, 64'h0, 64'h0, 8'd4},                    // R4
    '{1'b0, 6'h04, 4'd4, 64'h0, 64'h9ABC_DEF0, 8'd4},            // R4 lower page
    '{1'b1, 6'h16, 4'd2, 64'h2, 64'h0, 8'd8},                    // R8 select queue 2
    '{1'b0, 6'h16, 4'd2, 64'h0, 64'h2, 8'd8},                    // R8
    '{1'b0, 6'h1E, 4'd2, 64'h0, 64'h2, 8'd8},                    // R8 notify offset
    '{1'b1, 6'h18, 4'd2, 64'h100, 64'h0, 8'd9},                  // R9 size
    '{1'b0, 6'h18, 4'd2, 64'h0, 64'h100, 8'd9},                  // R9
    '{1'b1, 6'h1A, 4'd2, 64'h7, 64'h0, 8'd9},                    // R9 vector
    '{1'b0, 6'h1A, 4'd2, 64'h0, 64'h7, 8'd9},                    // R9
    '{1'b1, 6'h1C, 4'd2, 64'h1, 64'h0, 8'd10},                   // R10 enable
    '{1'b0, 6'h1C, 4'd2, 64'h0, 64'h1, 8'd10},                   // R10
    '{1'b1, 6'h1C, 4'd2, 64'h3, 64'h0, 8'd10},                   // R10 value 3 clears
    '{1'b0, 6'h1C, 4'd2, 64'h0, 64'h0, 8'd10},                   // R10
    '{1'b0, 6'h20, 4'd8, 64'h0, 64'h0, 8'd3},                    // R3 8-byte read
    '{1'b0, 6'h10, 4'd1, 64'h0, 64'h0, 8'd3},                    // R3 wrong size
    '{1'b0, 6'h14, 4'd4, 64'h0, 64'h0, 8'd3},                    // R3 wrong size
    '{1'b1, 6'h10, 4'd2, 64'hBEEF, 64'h0, 8'd3},                 // R3 config vector
    '{1'b0, 6'h10, 4'd2, 64'h0, 64'hBEEF, 8'd3},                 // R3
    '{1'b0, 6'h14, 4'd3, 64'h0, 64'h0, 8'd13},                   // R13 bad size read
    '{1'b1, 6'h14, 4'd3, 64'h11, 64'h0, 8'd13},                  // R13 bad size write
    '{1'b0, 6'h14, 4'd1, 64'h0, 64'h55, 8'd13},                  // R13 status kept
    '{1'b1, 6'h16, 4'd2, 64'h9, 64'h0, 8'd12},                   // R12 select out of range
    '{1'b0, 6'h18, 4'd2, 64'h0, 64'h0, 8'd12},                   // R12 read zero
    '{1'b1, 6'h18, 4'd2, 64'h40, 64'h0, 8'd12},                  // R12 write dropped
    '{1'b1, 6'h16, 4'd2, 64'h2, 64'h0, 8'd12},                   // R12
    '{1'b0, 6'h18, 4'd2, 64'h0, 64'h100, 8'd12},                 // R12 queue 2 intact
    '{1'b0, 6'h3C, 4'd4, 64'h0, 64'h0, 8'd13}                    // R13 unknown offset
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 / R1 reset state at the ports
    check("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R2 ack idle", {63'd0, feat_ack_valid}, 64'd0);
    check("R2 queue enables", {60'd0, q_enable_o}, 64'd0);
    check("R2 desc rings", q_desc_o[63:0] | q_desc_o[255:192], 64'd0);

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].wr, VEC[i].ofs, VEC[i].sz, VEC[i].data);
      if (!VEC[i].wr) check($sformatf("R%0d vector %0d", VEC[i].req, i), last_rd, VEC[i].exp);
      else            check($sformatf("R%0d vector %0d write rsp", VEC[i].req, i), last_rd, 64'd0);
    end

    // R9 queue 2 size on its output lane
    check("R9 q_size_o lane 2", {48'd0, q_size_o[32 +: 16]}, 64'h100);

    // R5 acknowledge on upper page, one cycle
    xact(1'b1, 6'h08, 4'd4, 64'h1);
    xact(1'b1, 6'h0C, 4'd4, 64'hCAFE_F00D);
    check("R5 ack valid", {63'd0, last_ack_v}, 64'd1);
    check("R5 ack bits upper", last_ack_bits, 64'hCAFE_F00D_0000_0000);
    @(negedge clk);
    check("R5 ack one cycle", {63'd0, feat_ack_valid}, 64'd0);
    xact(1'b1, 6'h08, 4'd4, 64'h0);
    xact(1'b1, 6'h0C, 4'd4, 64'h0000_0081);
    check("R5 ack bits lower", last_ack_bits, 64'h81);
    xact(1'b1, 6'h08, 4'd4, 64'h2);
    xact(1'b1, 6'h0C, 4'd4, 64'hFFFF_FFFF);
    check("R5 large select no ack", {63'd0, last_ack_v}, 64'd0);
    xact(1'b0, 6'h08, 4'd4, 64'h0);
    check("R6 driver select readback", last_rd, 64'h2);

    // R11 ring addresses on queue 1
    xact(1'b1, 6'h16, 4'd2, 64'h1);
    xact(1'b1, 6'h20, 4'd4, 64'h1111_1111);
    xact(1'b1, 6'h24, 4'd4, 64'h2222_2222);
    check("R11 desc halves", q_desc_o[64 +: 64], 64'h2222_2222_1111_1111);
    xact(1'b1, 6'h28, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD);
    check("R11 avail 64-bit", q_avail_o[64 +: 64], 64'hAAAA_BBBB_CCCC_DDDD);
    xact(1'b1, 6'h34, 4'd4, 64'h0000_0033);
    xact(1'b1, 6'h30, 4'd4, 64'h4444_0000);
    check("R11 used halves", q_used_o[64 +: 64], 64'h0000_0033_4444_0000);
    check("R11 other queue untouched", q_desc_o[128 +: 64], 64'd0);
    xact(1'b0, 6'h20, 4'd4, 64'h0);
    check("R11 ring not readable", last_rd, 64'd0);
    // R12 out-of-range ring write
    xact(1'b1, 6'h16, 4'd2, 64'h4);
    xact(1'b1, 6'h20, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R12 ring write dropped", q_desc_o[64 +: 64] ^ 64'h2222_2222_1111_1111
          | q_desc_o[192 +: 64], 64'd0);
    xact(1'b0, 6'h1E, 4'd2, 64'h0);
    check("R8 notify at oor select", last_rd, 64'h4);

    // R1 back-pressure
    xact(1'b1, 6'h16, 4'd2, 64'h3);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h16; req_size = 4'd2; req_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 6'h14; req_size = 4'd1;
    check("R1 ready low when stalled", {63'd0, req_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check("R1 held valid", {63'd0, rsp_valid}, 64'd1);
    check("R1 held data", rsp_rdata, 64'h3);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next response", rsp_rdata, 64'h55);
    @(negedge clk);
    check("R1 response drained", {63'd0, rsp_valid}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule